// File: doc/BRIEF.md
# Multi-bank outbound interrupt aggregator

This block collects up to 86 active-high, level-sensitive interrupt sources and forwards them to nine destination interrupt lines. Each source owns a pending flag that latches while its input is high and an enable flag. Each destination owns a set of routing masks, one per bank. The sources are grouped into three 32-bit banks, and software reaches every per-source flag through one 32-bit word per bank. The third bank has only 22 sources.

Software drives a simple synchronous register port. Enables can be changed only through a pair of write-one-to-set and write-one-to-clear words, so no read-modify-write is needed. Pending flags are acknowledged by writing ones. For every destination, a read-only identity word per bank shows which sources are pending, enabled and routed there. The destination line is the registered OR of those identity bits.

Top module: `outirq_aggregator`

## Requirements
- R1: Sources 0..85 map to bank 0 bits 0..31, bank 1 bits 0..31 and bank 2 bits 0..21. Bits 22..31 of every bank 2 word read as zero, and writes to them have no effect.
- R2: A pending flag is set after any rising clock edge at which its source input is high. It stays set after the input falls, and it can be read one edge after the source is sampled.
- R3: Writing a 1 to a bit of the pending words at byte offsets 0x30, 0x34 and 0x38 (banks 0, 1, 2) clears that flag. Bits written 0 leave their flags alone. If the source is high in the cycle of the clearing write, the flag stays set.
- R4: The enable state of banks 0, 1 and 2 reads back at offsets 0x48, 0x4C and 0x50. Writes to these words change nothing.
- R5: Ones written to offsets 0x54, 0x58 and 0x5C clear the matching enable bits. Ones written to 0x60, 0x64 and 0x68 set them. Zero bits leave enables unchanged, and an all-ones clear disables the whole bank.
- R6: The routing mask of destination n (0..8) sits at 0x78+4n for bank 0, 0x9C+4n for bank 1 and 0xC0+4n for bank 2. It is read/write, and a 1 routes that source to destination n.
- R7: The identity word of destination n sits at 0xE4+4n, 0x108+4n and 0x12C+4n for banks 0, 1 and 2. Each bit equals pending AND enable AND mask for that source. These words are read-only.
- R8: dst_irq[n] is high one edge after any identity bit of destination n is set. A source sampled high at one edge therefore raises the line at the second edge, and clearing the flag drops the line one edge after the clear.
- R9: Reset (rst_n low) clears all pending, enable and mask bits and drives every dst_irq low.
- R10: Reads of any other offset return zero, and writes to them change no state. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the word at bus_addr |
| bus_addr | input | 9 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| src_in | input | 86 | Level interrupt sources, active high |
| dst_irq | output | 9 | Destination interrupt lines, registered |

## Verification
Register writes, and the source sampling into the pending flags, take effect at the first rising edge. A readback therefore shows the new value from the falling edge after that edge, because bus_rdata is combinational. A destination line passes through one more register, so it follows its identity bits by one edge: a source raised before edge k shows on dst_irq after edge k+1. The bench drives and samples only at falling edges. Each check is placed after an explicit count of edges, so it sees the intermediate state (flag set, line still low) as well as the final one.

// File: rtl/outirq_aggregator.sv
module outirq_aggregator #(
  parameter int NSRC = 86,
  parameter int NDST = 9,
  parameter int AW   = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NSRC-1:0] src_in,
  output logic [NDST-1:0] dst_irq
);
  localparam int NBANK   = (NSRC + 31) / 32;
  localparam int PW      = NBANK * 32;
  localparam int IW      = AW - 2;
  localparam int W_PEND  = 12;
  localparam int W_ENA   = 18;
  localparam int W_CLR   = 21;
  localparam int W_SET   = 24;
  localparam int W_MAP   = 30;
  localparam int W_IDENT = W_MAP + NDST * NBANK;

  logic [IW-1:0] widx;
  logic [PW-1:0] impl, src_pad;
  logic [PW-1:0] sticky, sticky_nx, ena, ena_nx;
  logic [PW-1:0] map    [NDST];
  logic [PW-1:0] map_nx [NDST];
  logic [PW-1:0] ident  [NDST];

  assign widx    = bus_addr[AW-1:2];
  assign src_pad = PW'(src_in);

  always_comb
    for (int i = 0; i < PW; i++) impl[i] = (i < NSRC);

  always_comb begin
    sticky_nx = sticky;
    ena_nx    = ena;
    map_nx    = map;
    if (bus_wr) begin
      for (int b = 0; b < NBANK; b++) begin
        if (widx == IW'(W_PEND + b)) sticky_nx[b*32 +: 32] = sticky[b*32 +: 32] & ~bus_wdata;
        if (widx == IW'(W_CLR + b))  ena_nx[b*32 +: 32]    = ena[b*32 +: 32] & ~bus_wdata;
        if (widx == IW'(W_SET + b))  ena_nx[b*32 +: 32]    = ena[b*32 +: 32] | bus_wdata;
        for (int n = 0; n < NDST; n++)
          if (widx == IW'(W_MAP + NDST * b + n)) map_nx[n][b*32 +: 32] = bus_wdata;
      end
    end
    sticky_nx = (sticky_nx | src_pad) & impl;
    ena_nx    = ena_nx & impl;
    for (int n = 0; n < NDST; n++) map_nx[n] = map_nx[n] & impl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky <= '0;
      ena    <= '0;
      for (int n = 0; n < NDST; n++) map[n] <= '0;
    end else begin
      sticky <= sticky_nx;
      ena    <= ena_nx;
      map    <= map_nx;
    end
  end

  always_comb
    for (int n = 0; n < NDST; n++) ident[n] = sticky & ena & map[n];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dst_irq <= '0;
    else for (int n = 0; n < NDST; n++) dst_irq[n] <= |ident[n];
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (widx == IW'(W_PEND + b)) bus_rdata = sticky[b*32 +: 32];
      if (widx == IW'(W_ENA + b))  bus_rdata = ena[b*32 +: 32];
      for (int n = 0; n < NDST; n++) begin
        if (widx == IW'(W_MAP + NDST * b + n))   bus_rdata = map[n][b*32 +: 32];
        if (widx == IW'(W_IDENT + NDST * b + n)) bus_rdata = ident[n][b*32 +: 32];
      end
    end
  end
endmodule

// File: rtl/outirq_aggregator_chk.sv
module outirq_aggregator_chk #(
  parameter int NSRC = 86,
  parameter int NDST = 9,
  parameter int AW   = 9,
  parameter int PW   = 96
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic [AW-1:0]   bus_addr,
  input logic [31:0]     bus_wdata,
  input logic [NSRC-1:0] src_in,
  input logic [NDST-1:0] dst_irq,
  input logic [PW-1:0]   sticky,
  input logic [PW-1:0]   ena
);
  localparam int NBANK = PW / 32;
  logic [AW-3:0] w;
  logic          ena_wr;
  assign w      = bus_addr[AW-1:2];
  assign ena_wr = bus_wr && (int'(w) >= 21) && (int'(w) < 24 + NBANK);

  a_r2_source_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (src_in != '0) |=> ((sticky & PW'($past(src_in))) == PW'($past(src_in))));

  a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && int'(w) == 12 && src_in == '0) |=> ((sticky[31:0] & $past(bus_wdata)) == 32'h0));

  a_r5_enable_only_by_set_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !ena_wr |=> $stable(ena));

  a_r8_line_needs_pending_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_irq != '0) |-> $past((sticky & ena) != '0));
endmodule

bind outirq_aggregator outirq_aggregator_chk #(
  .NSRC(NSRC), .NDST(NDST), .AW(AW), .PW(PW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .src_in(src_in), .dst_irq(dst_irq),
  .sticky(sticky), .ena(ena)
);

// File: tb/sim_outirq_aggregator.sv
`timescale 1ns/1ps
module sim_outirq_aggregator;
  logic        clk = 0, rst_n = 0, bus_wr = 0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [85:0] src_in = '0;
  logic [8:0]  dst_irq;
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  outirq_aggregator u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in), .dst_irq(dst_irq));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [8:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(9'h030, d); check("R9 pending0", d, 0);
    rd(9'h048, d); check("R9 enable0", d, 0);
    rd(9'h078, d); check("R9 map0 dst0", d, 0);
    check("R9 dst_irq", 32'(dst_irq), 0);
  endtask

  task automatic t_pending();
    logic [31:0] d;
    @(negedge clk); src_in[5] = 1;
    @(negedge clk); src_in[5] = 0;
    rd(9'h030, d); check("R2 latch bit5", d, 32'h20);
    wr(9'h030, 32'h0); rd(9'h030, d); check("R3 zero write keeps", d, 32'h20);
    wr(9'h030, 32'h20); rd(9'h030, d); check("R3 ack clears", d, 0);
    @(negedge clk); src_in[5] = 1;
    wr(9'h030, 32'h20); rd(9'h030, d); check("R3 set wins over ack", d, 32'h20);
    @(negedge clk); src_in[5] = 0;
    wr(9'h030, 32'hFFFF_FFFF); rd(9'h030, d); check("R3 ack all", d, 0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(9'h048, 32'hFFFF_FFFF); rd(9'h048, d); check("R4 enable word read-only", d, 0);
    wr(9'h060, 32'h0000_00A5); wr(9'h060, 32'h0000_0100);
    rd(9'h048, d); check("R5 set accumulates", d, 32'h0000_01A5);
    wr(9'h054, 32'h0000_0001); rd(9'h048, d); check("R5 clear one", d, 32'h0000_01A4);
    wr(9'h054, 32'h0); rd(9'h048, d); check("R5 zero clear keeps", d, 32'h0000_01A4);
    wr(9'h054, 32'hFFFF_FFFF); rd(9'h048, d); check("R5 clear all", d, 0);
  endtask

  task automatic t_route_timing();
    logic [31:0] d;
    wr(9'h060, 32'h20); wr(9'h078, 32'h20);
    rd(9'h078, d); check("R6 map readback", d, 32'h20);
    @(negedge clk); src_in[5] = 1;
    @(negedge clk); check("R8 line low after first edge", 32'(dst_irq[0]), 0);
    rd(9'h0E4, d); check("R7 ident dst0", d, 32'h20);
    check("R8 line high after second edge", 32'(dst_irq[0]), 1);
    check("R6 other dst idle", 32'(dst_irq[8:1]), 0);
    src_in[5] = 0;
    wr(9'h0E4, 32'h0); rd(9'h0E4, d); check("R7 ident read-only", d, 32'h20);
    wr(9'h030, 32'h20);
    check("R8 line still high at clear edge", 32'(dst_irq[0]), 1);
    @(negedge clk); check("R8 line drops", 32'(dst_irq[0]), 0);
    wr(9'h054, 32'hFFFF_FFFF); wr(9'h078, 0);
  endtask

  task automatic t_banks();
    logic [31:0] d;
    wr(9'h064, 32'h100); wr(9'h0A8, 32'h100);
    @(negedge clk); src_in[40] = 1;
    @(negedge clk); src_in[40] = 0;
    rd(9'h034, d); check("R1 src40 bank1 bit8", d, 32'h100);
    rd(9'h114, d); check("R7 ident bank1 dst3", d, 32'h100);
    check("R8 dst3 high", 32'(dst_irq), 32'h008);
    wr(9'h068, 32'hFFFF_FFFF); rd(9'h050, d); check("R1 bank2 enable width", d, 32'h003F_FFFF);
    wr(9'h0E0, 32'hFFFF_FFFF); rd(9'h0E0, d); check("R6 bank2 mask width", d, 32'h003F_FFFF);
    @(negedge clk); src_in[85] = 1;
    @(negedge clk); src_in[85] = 0;
    rd(9'h038, d); check("R1 src85 bank2 bit21", d, 32'h0020_0000);
    rd(9'h14C, d); check("R7 ident bank2 dst8", d, 32'h0020_0000);
    check("R8 dst3 and dst8", 32'(dst_irq), 32'h108);
    wr(9'h034, 32'hFFFF_FFFF); wr(9'h038, 32'hFFFF_FFFF);
    @(negedge clk); check("R8 all lines low", 32'(dst_irq), 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(9'h000, 32'hFFFF_FFFF); rd(9'h000, d); check("R10 offset 0", d, 0);
    wr(9'h040, 32'hFFFF_FFFF); rd(9'h040, d); check("R10 offset 0x40", d, 0);
    wr(9'h150, 32'hFFFF_FFFF); rd(9'h150, d); check("R10 offset 0x150", d, 0);
    rd(9'h048, d); check("R10 no side effect enable0", d, 0);
    rd(9'h07C, d); check("R10 no side effect map0 dst1", d, 0);
    rd(9'h052, d); check("R10 low bits ignored", d, 32'h003F_FFFF);
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_pending();
    t_enable();
    t_route_timing();
    t_banks();
    t_unmapped();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule